// File: doc/BRIEF.md
# Recirculating Morse Message Store

This block keeps a short Morse message in a closed loop of shift stages, so it needs no address counter or decoder. While a message is being keyed, each accepted keying sample enters the head of the loop. During playback the loop rotates continuously, and the bit leaving the tail drives the keying output. Blank cells (key up) are held as logic 1 inside the loop and keyed cells as logic 0. With this inverted storage, a freshly erased loop and the gaps of a message look the same.

The loop is split into `SECT_CNT` sections of `SECT_LEN` stages each. A load always begins by writing `SYNC_LEN` blanks, and playback uses that run to find where the message starts. During playback, once more than `SYNC_LEN` blanks in a row have left the tail, the loop steps on the fast strobe. It returns to the normal strobe just before the next keyed bit emerges, so long silences pass quickly. A capacity warning lights when only `SYNC_LEN` free cells are left. In clear mode the loop is flushed with blanks at the fast rate. In off mode the keyed bit passes straight through and nothing moves.

The two rate strobes, `tick_norm` and `tick_fast`, are single-cycle clock enables that come from outside the block. Keying can therefore be recorded at one speed and replayed at another.

Top module: `msgmem_top`

## Requirements
- R1: After reset every loop cell is blank, the load count is zero, `full_led` is low, and `key_out` is low with `key_bit` low.
- R2: The mode code 2'b00 selects off mode. In off mode `key_out` equals `key_bit`, and strobes neither move the loop nor change the load count.
- R3: Mode code 2'b01 selects load mode, where `key_out` equals `key_bit`. The first `SYNC_LEN` accepted `tick_norm` pulses after a clear write blanks whatever `key_busy` is. Every later `tick_norm` pulse writes the inverse of `key_bit` only while `key_busy` is high. With `key_busy` low, pulses are dropped and no blank is stored.
- R4: Mode code 2'b10 selects read mode. There the loop moves one place per accepted strobe and the tail bit, inverted, appears on `key_out`, so the bits come out in the order they were loaded and keyed bits give `key_out` high.
- R5: In read mode, once `SYNC_LEN`+1 consecutive blanks have left the tail and the next cell to emerge is blank, the loop steps only on `tick_fast` and ignores `tick_norm`. When the next cell to emerge is keyed, stepping returns to `tick_norm` before that cell reaches the output.
- R6: After read mode is entered, `key_out` stays low until `SYNC_LEN` consecutive blanks have left the tail.
- R7: Outside clear mode `full_led` is high exactly when the load count is at least `SECT_LEN*SECT_CNT - SYNC_LEN`. Loading stops once the count reaches the loop length.
- R8: Mode code 2'b11 selects clear mode. There the loop steps only on `tick_fast` and takes in blanks, `key_out` is low, and the load count returns to zero. `full_led` is high from entry until `SECT_LEN*SECT_CNT` fast pulses have been taken.
- R9: `data_led` always equals `key_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Operating mode: 00 off, 01 load, 10 read, 11 clear |
| key_bit | input | 1 | Keyed data from the keyer, 1 = key down |
| key_busy | input | 1 | High while the keyer is producing an element or space |
| tick_norm | input | 1 | Normal-rate shift strobe, one cycle wide |
| tick_fast | input | 1 | Fast-rate shift strobe, one cycle wide |
| key_out | output | 1 | Keying output, 1 = key down |
| data_led | output | 1 | Indicator copy of the keying output |
| full_led | output | 1 | Capacity warning, or erase in progress in clear mode |

## Verification
The bench builds the block with 8-stage sections, four of them, and a 4-blank sync run, which gives a 32-cell loop. At that size the bench can walk the whole path by hand. It can count every fast step from the start of read mode to the first keyed cell, cross the 28-cell capacity warning, and take the full 32-pulse erase. Because the loop is short, the bench can know the exact position of every message bit at each strobe. This makes the switch back to the normal rate, the muting after re-entry and the dropping of idle load pulses observable bit by bit on `key_out`.

// File: rtl/msgmem_pkg.sv
`timescale 1ns/1ps
package msgmem_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } mem_mode_e;
endpackage

// File: rtl/msgmem_sect.sv
`timescale 1ns/1ps
// One section of the loop: a plain shift chain, blank (1) after reset.
module msgmem_sect #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {sr_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[LEN-1];
endmodule

// File: rtl/msgmem_ring.sv
`timescale 1ns/1ps
// Loop of sections. The last section is one stage short and a separate
// tail stage follows it, so the cell about to emerge is visible.
module msgmem_ring #(
  parameter int SECT_LEN = 64,
  parameter int SECT_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic tail,
  output logic pre_tail
);
  logic [SECT_CNT:0] link;
  logic tail_q;
  logic tail_d;

  assign link[0] = din;

  for (genvar i = 0; i < SECT_CNT; i++) begin : g_sect
    localparam int STAGES = (i == SECT_CNT - 1) ? SECT_LEN - 1 : SECT_LEN;
    msgmem_sect #(.LEN(STAGES)) u_sect (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (shift_en),
      .din  (link[i]),
      .dout (link[i+1])
    );
  end

  assign pre_tail = link[SECT_CNT];

  always_comb begin
    tail_d = tail_q;
    if (shift_en) tail_d = pre_tail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail_q <= 1'b1;
    else        tail_q <= tail_d;
  end

  assign tail = tail_q;
endmodule

// File: rtl/msgmem_ctrl.sv
`timescale 1ns/1ps
// Load and erase bookkeeping: load count, erase count, capacity warning.
module msgmem_ctrl
  import msgmem_pkg::*;
#(
  parameter int TOTAL    = 512,
  parameter int SYNC_LEN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  mem_mode_e mode,
  input  logic      tick_norm,
  input  logic      tick_fast,
  input  logic      key_bit,
  input  logic      key_busy,
  output logic      load_shift,
  output logic      clear_shift,
  output logic      wr_bit,
  output logic      full_led
);
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] SYNC_C  = CNT_W'(SYNC_LEN);
  localparam logic [CNT_W-1:0] WARN_C  = CNT_W'(TOTAL - SYNC_LEN);

  logic [CNT_W-1:0] ld_q, ld_d;
  logic [CNT_W-1:0] clr_q, clr_d;
  logic in_sync;
  logic is_load;
  logic is_clear;

  assign is_load  = (mode == MODE_LOAD);
  assign is_clear = (mode == MODE_CLEAR);
  assign in_sync  = (ld_q < SYNC_C);

  always_comb begin
    load_shift  = is_load && tick_norm && (ld_q != TOTAL_C) && (in_sync || key_busy);
    clear_shift = is_clear && tick_fast && (clr_q != TOTAL_C);
    wr_bit      = is_clear || in_sync || !key_bit;
    full_led    = is_clear ? (clr_q != TOTAL_C) : (ld_q >= WARN_C);
  end

  always_comb begin
    ld_d = ld_q;
    if (is_clear)        ld_d = '0;
    else if (load_shift) ld_d = ld_q + 1'b1;
  end

  always_comb begin
    clr_d = clr_q;
    if (!is_clear)        clr_d = '0;
    else if (clear_shift) clr_d = clr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= '0;
      clr_q <= '0;
    end else begin
      ld_q  <= ld_d;
      clr_q <= clr_d;
    end
  end
endmodule

// File: rtl/msgmem_gap.sv
`timescale 1ns/1ps
// Playback pacing: blank-run counter, rate select, start-of-message gate.
module msgmem_gap
  import msgmem_pkg::*;
#(
  parameter int SYNC_LEN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  mem_mode_e mode,
  input  logic      tick_norm,
  input  logic      tick_fast,
  input  logic      pre_tail,
  output logic      read_shift,
  output logic      fast_sel,
  output logic      synced
);
  localparam int RUN_W = $clog2(SYNC_LEN + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SYNC_LEN + 1);
  localparam logic [RUN_W-1:0] SYNC_M1 = RUN_W'(SYNC_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic sync_q, sync_d;
  logic is_read;

  assign is_read = (mode == MODE_READ);

  always_comb begin
    fast_sel   = is_read && (run_q == RUN_MAX) && pre_tail;
    read_shift = is_read && (fast_sel ? tick_fast : tick_norm);
  end

  always_comb begin
    run_d  = run_q;
    sync_d = sync_q;
    if (!is_read) begin
      run_d  = '0;
      sync_d = 1'b0;
    end else if (read_shift) begin
      if (pre_tail) begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        if (run_q >= SYNC_M1) sync_d = 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      sync_q <= sync_d;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/msgmem_top.sv
`timescale 1ns/1ps
module msgmem_top
  import msgmem_pkg::*;
#(
  parameter int SECT_LEN = 64,
  parameter int SECT_CNT = 8,
  parameter int SYNC_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       key_bit,
  input  logic       key_busy,
  input  logic       tick_norm,
  input  logic       tick_fast,
  output logic       key_out,
  output logic       data_led,
  output logic       full_led
);
  localparam int TOTAL = SECT_LEN * SECT_CNT;

  logic [1:0] rst_pipe_q;
  logic rst_int_n;
  mem_mode_e mode_e;
  logic load_shift, clear_shift, read_shift, shift_en;
  logic wr_bit, ring_din, tail, pre_tail;
  logic fast_sel, synced;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign mode_e = mem_mode_e'(mode);

  msgmem_ctrl #(.TOTAL(TOTAL), .SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode       (mode_e),
    .tick_norm  (tick_norm),
    .tick_fast  (tick_fast),
    .key_bit    (key_bit),
    .key_busy   (key_busy),
    .load_shift (load_shift),
    .clear_shift(clear_shift),
    .wr_bit     (wr_bit),
    .full_led   (full_led)
  );

  msgmem_gap #(.SYNC_LEN(SYNC_LEN)) u_gap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode_e),
    .tick_norm (tick_norm),
    .tick_fast (tick_fast),
    .pre_tail  (pre_tail),
    .read_shift(read_shift),
    .fast_sel  (fast_sel),
    .synced    (synced)
  );

  assign shift_en = load_shift | clear_shift | read_shift;
  assign ring_din = (mode_e == MODE_READ) ? tail : wr_bit;

  msgmem_ring #(.SECT_LEN(SECT_LEN), .SECT_CNT(SECT_CNT)) u_ring (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_en(shift_en),
    .din     (ring_din),
    .tail    (tail),
    .pre_tail(pre_tail)
  );

  always_comb begin
    unique case (mode_e)
      MODE_OFF:   key_out = key_bit;
      MODE_LOAD:  key_out = key_bit;
      MODE_READ:  key_out = synced & ~tail;
      MODE_CLEAR: key_out = 1'b0;
      default:    key_out = 1'b0;
    endcase
  end

  assign data_led = key_out;
endmodule

// File: rtl/msgmem_sva.sv
`timescale 1ns/1ps
module msgmem_sva
  import msgmem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       key_bit,
  input logic       tick_fast,
  input logic       tick_norm,
  input logic       key_out,
  input logic       data_led,
  input logic       full_led,
  input logic       shift_en,
  input logic       fast_sel
);
  p_led_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_led == key_out);

  p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> (key_out == key_bit) && !shift_en);

  p_load_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD && !tick_norm) |-> !shift_en);

  p_fast_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |-> (mode == MODE_READ));

  p_entry_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_READ && $past(mode) != MODE_READ) |-> !key_out);

  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |-> !key_out);

  p_clear_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR && !tick_fast) |=> (mode != MODE_CLEAR || $stable(full_led)));

  p_clear_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR && !tick_fast && tick_norm) |-> !shift_en);
endmodule

bind msgmem_top msgmem_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .key_bit  (key_bit),
  .tick_fast(tick_fast),
  .tick_norm(tick_norm),
  .key_out  (key_out),
  .data_led (data_led),
  .full_led (full_led),
  .shift_en (shift_en),
  .fast_sel (fast_sel)
);

// File: tb/msgmem_top_bench.sv
`timescale 1ns/1ps
module msgmem_top_bench;
  import msgmem_pkg::*;

  localparam int SL = 8;
  localparam int SC = 4;
  localparam int SY = 4;
  localparam int TOT = SL * SC;
  localparam int MLEN = 5;

  logic clk;
  logic rst_n;
  logic [1:0] mode;
  logic key_bit, key_busy, tick_norm, tick_fast;
  logic key_out, data_led, full_led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [MLEN-1:0] msg = 5'b11011; // msg[0] sent first

  msgmem_top #(.SECT_LEN(SL), .SECT_CNT(SC), .SYNC_LEN(SY)) u_msgmem_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .key_bit  (key_bit),
    .key_busy (key_busy),
    .tick_norm(tick_norm),
    .tick_fast(tick_fast),
    .key_out  (key_out),
    .data_led (data_led),
    .full_led (full_led)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic n, input logic f);
    @(negedge clk);
    tick_norm = n;
    tick_fast = f;
    @(negedge clk);
    tick_norm = 1'b0;
    tick_fast = 1'b0;
  endtask

  task automatic set_mode(input mem_mode_e m);
    @(negedge clk);
    mode = m;
    #1;
  endtask

  task automatic do_clear();
    set_mode(MODE_CLEAR);
    for (int i = 0; i < TOT; i++) pulse(1'b0, 1'b1);
  endtask

  // load sync run then msg, with idle pulses between bits
  task automatic do_load(input bit check_it);
    set_mode(MODE_LOAD);
    key_busy = 1'b0;
    key_bit  = 1'b0;
    for (int i = 0; i < SY; i++) pulse(1'b1, 1'b0);
    for (int i = 0; i < MLEN; i++) begin
      key_bit  = msg[i];
      key_busy = 1'b1;
      pulse(1'b1, 1'b0);
      if (check_it) begin
        chk("R3 key_out follows key_bit in load", key_out, msg[i]);
        chk("R9 data_led mirror", data_led, key_out);
      end
      key_busy = 1'b0;
      key_bit  = 1'b1;            // idle pulses must store nothing
      pulse(1'b1, 1'b0);
      pulse(1'b1, 1'b0);
    end
    key_bit = 1'b0;
  endtask

  task automatic t_reset();
    mode = MODE_OFF; key_bit = 0; key_busy = 0; tick_norm = 0; tick_fast = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 full_led after reset", full_led, 1'b0);
    chk("R1 key_out after reset", key_out, 1'b0);
    chk("R1 data_led after reset", data_led, 1'b0);
  endtask

  // Loop of 32: after load, tail sits at old blank cell 31, msg[0] at cell 4
  task automatic t_playback();
    do_load(1'b1);
    set_mode(MODE_READ);
    chk("R6 muted on read entry", key_out, 1'b0);
    for (int i = 0; i < SY + 1; i++) begin
      pulse(1'b1, 1'b0);
      chk("R4 leading blanks read low", key_out, 1'b0);
    end
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b1);
    for (int i = 0; i < 15; i++) begin
      pulse(1'b1, 1'b0);           // ignored while skipping
      chk("R5 normal strobe ignored while skipping", key_out, 1'b0);
    end
    for (int i = 0; i < 20; i++) pulse(1'b0, 1'b1); // only 11 take effect
    chk("R5 fast skip stops before data", key_out, 1'b0);
    for (int i = 0; i < MLEN; i++) begin
      pulse(1'b1, 1'b0);
      chk("R4 R5 playback bit on normal strobe", key_out, msg[i]);
      chk("R9 data_led mirror in read", data_led, msg[i]);
    end
  endtask

  task automatic t_resync();
    do_clear();
    do_load(1'b0);
    set_mode(MODE_READ);
    for (int i = 0; i < SY + 1; i++) pulse(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    chk("R4 first bit before re-entry", key_out, msg[0]);
    set_mode(MODE_OFF);
    set_mode(MODE_READ);
    for (int i = 1; i < MLEN; i++) begin
      pulse(1'b1, 1'b0);
      chk("R6 output muted until sync run seen", key_out, 1'b0);
    end
  endtask

  task automatic t_full_off();
    do_clear();
    set_mode(MODE_LOAD);
    key_busy = 1'b0;
    for (int i = 0; i < SY; i++) pulse(1'b1, 1'b0);
    key_busy = 1'b1; key_bit = 1'b1;
    for (int i = 0; i < TOT - 2 * SY - 1; i++) pulse(1'b1, 1'b0);
    chk("R7 full_led low one cell before threshold", full_led, 1'b0);
    set_mode(MODE_OFF);
    key_bit = 1'b0; #1;
    chk("R2 passthrough low", key_out, 1'b0);
    key_bit = 1'b1; #1;
    chk("R2 passthrough high", key_out, 1'b1);
    chk("R9 data_led mirror in off", data_led, 1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1);
    chk("R2 off strobes leave count", full_led, 1'b0);
    set_mode(MODE_LOAD);
    chk("R2 count unchanged after off", full_led, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R7 full_led at threshold", full_led, 1'b1);
    for (int i = 0; i < SY + 2; i++) pulse(1'b1, 1'b0);
    chk("R7 full_led at capacity", full_led, 1'b1);
  endtask

  task automatic t_clear();
    key_bit = 1'b1;
    set_mode(MODE_CLEAR);
    chk("R8 full_led on clear entry", full_led, 1'b1);
    chk("R8 key_out low in clear", key_out, 1'b0);
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    chk("R8 normal strobe ignored in clear", full_led, 1'b1);
    for (int i = 0; i < TOT - 1; i++) pulse(1'b0, 1'b1);
    chk("R8 full_led held one pulse short", full_led, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R8 full_led off after whole pass", full_led, 1'b0);
    key_bit = 1'b0;
    set_mode(MODE_READ);
    chk("R7 R8 count reset after clear", full_led, 1'b0);
    for (int i = 0; i < TOT + 8; i++) begin
      pulse(1'b1, 1'b1);
      chk("R8 erased loop plays silence", key_out, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_playback();
    t_resync();
    t_full_off();
    t_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule